// File: doc/BRIEF.md
# Lazy-Promotion Eviction Selector

This block keeps the replacement state for a small fully associative buffer of `N` slots. It holds no tags and no data. It tracks which slots hold live entries and the order in which those entries were installed, oldest first. Each slot also has one "touched" flag that is set when the slot is hit after it was installed. A hit only sets the flag. It never promotes the entry, so the queue order and the sweep pointer are left untouched.

When the surrounding cache needs room, it pulses a victim request. If any slot is empty, that slot is offered at once. Otherwise a sweep pointer walks the queue from its current position toward the newest end, one entry per cycle. It clears the touched flags it passes and wraps back to the oldest end after the newest. The first untouched entry becomes the victim. The pointer stays on the victim's queue position. When the replacement is installed, the victim's old position is closed up and the newcomer joins at the newest end. The pointer therefore lands on the entry that was just newer than the victim, or on the oldest entry if the victim was the newest.

Top module: `lazy_evict_sel`

## Requirements
- R1: After reset every slot is empty, the queue is empty, the sweep pointer is at the oldest end and `vic_valid_o` is 0.
- R2: A victim request made while any slot is empty yields the lowest-numbered empty slot. `vic_valid_o` rises one cycle after the request, and the sweep pointer does not move.
- R3: A hit sets the touched flag of slot `hit_idx_i`. It does not change the queue order or the sweep pointer.
- R4: An install writes slot `ins_idx_i` at the newest end of the queue, marks it live and clears its touched flag.
- R5: With all slots live, the sweep looks at one queue position per cycle, starting at the pointer. A touched entry has its flag cleared and the pointer advances. The first untouched entry is the victim. `vic_valid_o` rises after exactly as many cycles as positions were examined.
- R6: The pointer wraps from the newest end to the oldest end. When every flag is set, the victim is the entry that started under the pointer, and it is reported after N+1 cycles.
- R7: Once raised, `vic_valid_o` stays 1 and `vic_idx_o` stays constant until an install, which drops `vic_valid_o` in the next cycle.
- R8: Installing over a swept victim removes the victim from its queue position, keeps the relative order of all other entries, and leaves the pointer on the next-newer entry (the oldest if the victim was the newest).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 1 | Lookup hit strobe |
| hit_idx_i | input | $clog2(N) | Slot that hit |
| vic_req_i | input | 1 | One-cycle request for a victim |
| ins_i | input | 1 | Install strobe |
| ins_idx_i | input | $clog2(N) | Slot being installed |
| vic_valid_o | output | 1 | Victim chosen and held |
| vic_idx_o | output | $clog2(N) | Slot to overwrite |

## Verification
The assertions assume a well-behaved caller, and the bench follows each rule. A victim request arrives only when no sweep is running and no victim is pending. An install arrives only when no sweep is running, and it names the pending victim when there is one and an empty slot otherwise. No hit targets the slot under the pointer during a sweep or the pending victim. The bench issues its hits, requests and installs one at a time, on falling edges and strictly in sequence, so these conditions hold by the way the stimulus is ordered. Its own queue model predicts each victim and latency over every flag pattern of a four-slot configuration.

// File: rtl/lazy_evict_sel.sv
module lazy_evict_sel #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [IW-1:0] hit_idx_i,
  input  logic          vic_req_i,
  input  logic          ins_i,
  input  logic [IW-1:0] ins_idx_i,
  output logic          vic_valid_o,
  output logic [IW-1:0] vic_idx_o
);
  typedef enum logic [1:0] {S_IDLE, S_SEEK, S_FOUND} st_t;

  st_t           st;
  logic [IW-1:0] q [N];
  logic [N-1:0]  val, vis;
  logic [CW-1:0] cnt;
  logic [IW-1:0] hand, vidx, free_idx, hslot, hand_adv;
  logic          from_free, any_free, hvis, hand_at_head, step_en;

  assign any_free     = ~&val;
  assign hslot        = q[hand];
  assign hvis         = vis[hslot];
  assign hand_at_head = (CW'(hand) == cnt - CW'(1));
  assign hand_adv     = hand_at_head ? '0 : hand + 1'b1;
  assign step_en      = (st == S_SEEK) ||
                        (st == S_IDLE && vic_req_i && !ins_i && !any_free);
  assign vic_valid_o  = (st == S_FOUND);
  assign vic_idx_o    = vidx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!val[i]) free_idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      val       <= '0;
      vis       <= '0;
      cnt       <= '0;
      hand      <= '0;
      vidx      <= '0;
      from_free <= 1'b0;
      for (int i = 0; i < N; i++) q[i] <= '0;
    end else begin
      if (hit_i) vis[hit_idx_i] <= 1'b1;

      if (step_en) begin
        if (!hvis) begin
          vidx      <= hslot;
          from_free <= 1'b0;
          st        <= S_FOUND;
        end else begin
          vis[hslot] <= 1'b0;
          hand       <= hand_adv;
          st         <= S_SEEK;
        end
      end

      case (st)
        S_IDLE: begin
          if (ins_i) begin
            q[IW'(cnt)]    <= ins_idx_i;
            cnt            <= cnt + 1'b1;
            val[ins_idx_i] <= 1'b1;
            vis[ins_idx_i] <= 1'b0;
          end else if (vic_req_i && any_free) begin
            vidx      <= free_idx;
            from_free <= 1'b1;
            st        <= S_FOUND;
          end
        end
        S_FOUND: begin
          if (ins_i) begin
            if (from_free) begin
              q[IW'(cnt)] <= ins_idx_i;
              cnt         <= cnt + 1'b1;
            end else begin
              for (int i = 0; i < N - 1; i++)
                if (i >= int'(hand) && i + 1 < int'(cnt)) q[i] <= q[i+1];
              q[IW'(cnt - CW'(1))] <= ins_idx_i;
              if (hand_at_head) hand <= '0;
            end
            val[ins_idx_i] <= 1'b1;
            vis[ins_idx_i] <= 1'b0;
            st             <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  logic [CW:0] seek_len;
  always_ff @(posedge clk) begin
    if (!rst_n)       seek_len <= '0;
    else if (step_en && hvis) seek_len <= seek_len + 1'b1;
    else              seek_len <= '0;
  end

  a_r6_bounded_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    int'(seek_len) <= N);

  a_r7_victim_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid_o && !ins_i) |=> (vic_valid_o && $stable(vic_idx_o)));

  a_r3_hit_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !vic_req_i && !ins_i) |=> ($stable(hand) && $stable(cnt)));

  a_r4_count_matches_live: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(val) == int'(cnt));

  a_r5_victim_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vic_valid_o) |-> (!val[vidx] || !vis[vidx]));

  a_r2_free_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && vic_req_i && !ins_i && any_free) |=> $stable(hand));
endmodule

// File: tb/sim_lazy_evict_sel.sv
`timescale 1ns/1ps
module sim_lazy_evict_sel;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic hit_i = 0, vic_req_i = 0, ins_i = 0;
  logic [IW-1:0] hit_idx_i = '0, ins_idx_i = '0;
  logic vic_valid_o;
  logic [IW-1:0] vic_idx_o;

  lazy_evict_sel #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .hit_idx_i(hit_idx_i),
    .vic_req_i(vic_req_i), .ins_i(ins_i), .ins_idx_i(ins_idx_i),
    .vic_valid_o(vic_valid_o), .vic_idx_o(vic_idx_o));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int mq [N];
  int mval [N];
  int mvis [N];
  int mcnt = 0, mhand = 0, mfree = 0, last_vic = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_hit(input int s);
    @(negedge clk); hit_i = 1; hit_idx_i = IW'(s);
    @(negedge clk); hit_i = 0;
    mvis[s] = 1;
  endtask

  task automatic do_req(input string tag);
    int eidx, elat, lat, m, s;
    eidx = -1;
    for (int i = N - 1; i >= 0; i--) if (mval[i] == 0) eidx = i;
    if (eidx >= 0) begin
      elat = 1; mfree = 1;
    end else begin
      m = 0; mfree = 0;
      forever begin
        m++;
        s = mq[mhand];
        if (mvis[s] == 0) break;
        mvis[s] = 0;
        mhand = (mhand == mcnt - 1) ? 0 : mhand + 1;
      end
      eidx = s; elat = m;
    end
    @(negedge clk); vic_req_i = 1;
    @(negedge clk); vic_req_i = 0;
    lat = 1;
    while (!vic_valid_o && lat < 20) begin
      @(negedge clk); lat++;
    end
    chk(tag, lat, elat);
    chk(tag, int'(vic_idx_o), eidx);
    last_vic = int'(vic_idx_o);
    // R7: victim held while no install arrives
    repeat (2) @(negedge clk);
    chk("R7", int'(vic_valid_o), 1);
    chk("R7", int'(vic_idx_o), eidx);
  endtask

  task automatic do_ins(input int s, input bit pending);
    @(negedge clk); ins_i = 1; ins_idx_i = IW'(s);
    @(negedge clk); ins_i = 0;
    if (pending && !mfree) begin
      for (int i = mhand; i < mcnt - 1; i++) mq[i] = mq[i+1];
      mq[mcnt-1] = s;
      if (mhand == mcnt - 1) mhand = 0;
    end else begin
      mq[mcnt] = s; mcnt++;
    end
    mval[s] = 1; mvis[s] = 0;
    if (pending) chk("R7", int'(vic_valid_o), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mq[i] = 0; mval[i] = 0; mvis[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(vic_valid_o), 0);
    // R1/R2: empty buffer offers slot 0 after one cycle
    do_req("R2");
    do_ins(last_vic, 1);
    do_ins(3, 0);               // R4: install into empty slot at newest end
    do_req("R2");               // lowest empty is 1
    do_ins(last_vic, 1);
    do_ins(2, 0);               // queue oldest..newest: 0,3,1,2
    // R3: hits only flag; pointer still at oldest, order unchanged
    do_hit(3); do_hit(0);
    do_req("R3");               // sweeps 0,3 then picks 1 after 3 cycles
    do_ins(last_vic, 1);        // R8: pointer now on entry newer than victim
    // R4: freshly installed entry is untouched, so with all others hit it is chosen
    do_hit(0); do_hit(2); do_hit(3);
    do_req("R4");
    do_ins(last_vic, 1);
    // R5/R6/R8: sweep every touched-flag pattern, twice over
    for (int it = 0; it < 32; it++) begin
      int pat;
      pat = (it * 7 + 3) % 16;
      for (int b = 0; b < N; b++) if (pat[b]) do_hit(b);
      do_req((pat == 15) ? "R6" : "R5");
      do_ins(last_vic, 1);      // R8 removal and pointer update
    end
    // R6: all touched, explicit worst case
    for (int b = 0; b < N; b++) do_hit(b);
    do_req("R6");
    do_ins(last_vic, 1);
    do_req("R8");
    do_ins(last_vic, 1);
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule